// File: doc/BRIEF.md
# SPI Word Shift Engine

This block is the serial core of an SPI master. It pops 32-bit entries from a transmit FIFO, shifts each SPI word out on MOSI most significant bit first, collects the bits returned on MISO (or, in loopback, its own MOSI), and pushes each received word into a receive FIFO. The word length can be anything from 4 to 32 bits. Clock polarity, sampling phase and the number of words in a transfer are latched when a transfer starts.

Data alignment differs between the two directions. A transmit entry carries the word in its upper bytes: one, two or four bytes, depending on the word length. A receive entry is right-justified, with the upper bits zero. Chip select stays asserted across all the words of a transfer. When the transmit FIFO runs dry partway through a transfer, the serial clock pauses until more data arrives, so no stale bits are sent. A half-period divider sets the SCLK rate.

Top module: `spi_word_shifter`

## Requirements
- R1: `cfg_len_m1` holds the word length minus one. Field values 0 to 2 are treated as 3, so the shortest word is 4 bits.
- R2: A transmit entry's byte class B is 1 byte for words up to 8 bits, 2 bytes up to 16 bits and 4 bytes otherwise. The word is the low N bits of the field `tx_data[31:32-8B]`. Field bits above N, and all bits below the field, are ignored.
- R3: Each received word appears on `rx_data` right-justified in bits [N-1:0], with all higher bits zero, in the cycle `rx_push` is high.
- R4: Within a word, bits are sent and received most significant bit first, one bit per SCLK period.
- R5: Outside a transfer and between words, SCLK rests at the level given by `cfg_idle_high` (1 means high).
- R6: With `cfg_input_first`=1, the leading SCLK edge of each bit samples and the trailing edge shifts. With it at 0, the leading edge shifts and the trailing edge samples. Each half of an SCLK period lasts HALF_DIV clock cycles.
- R7: With `cfg_loopback`=1, the received bits are the block's own MOSI bits and `miso` has no effect.
- R8: A transfer started with word count K pops exactly K entries and pushes exactly K words, then stops. A start with a count of 0 is ignored.
- R9: `cs_n` falls in the cycle after an accepted start. It rises exactly 2*HALF_DIV cycles after the cycle in which the final word is pushed.
- R10: While a word is needed and `tx_valid` is low, the engine pops nothing, SCLK holds its idle level and chip select stays asserted. Shifting resumes once data is available.
- R11: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, and neither `tx_pop` nor `rx_push` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_idle_high | input | 1 | SCLK idle level |
| cfg_input_first | input | 1 | Sample on the leading edge when set |
| cfg_loopback | input | 1 | Route MOSI internally to the receive path |
| cfg_word_count | input | CNT_W | Words in the transfer |
| tx_data | input | 32 | Head entry of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | Pop the transmit FIFO head |
| rx_data | output | 32 | Received word, right-justified |
| rx_push | output | 1 | Push `rx_data` into the receive FIFO |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions check four things on every cycle: pops happen only when data is present and chip select is low; pushes never exceed the latched word count; SCLK and MOSI stay still while the engine waits for data; and chip select releases only from the tail phase. Only the bench's scenarios can show that the bit order, the transmit field extraction, the right-justified receive format, the edge choice for each phase setting and loopback are correct. The bench shows this by running a slave model against every mode and a sweep of word lengths. The exact release delay of chip select and the clamping of short length codes are also covered only by those scenarios.

// File: rtl/spi_ws_pkg.sv
package spi_ws_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } ws_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len_m1;
        logic             idle_high;
        logic             input_first;
        logic             loopback;
    } ws_cfg_t;

    // bytes a word occupies inside a FIFO entry
    function automatic logic [2:0] byte_class(input logic [LEN_W-1:0] len_m1);
        if (len_m1 <= LEN_W'(7))
            return 3'd1;
        else if (len_m1 <= LEN_W'(15))
            return 3'd2;
        else
            return 3'd4;
    endfunction

    // shortest legal word is four bits
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len_m1);
        return (len_m1 < LEN_W'(3)) ? LEN_W'(3) : len_m1;
    endfunction

endpackage

// File: rtl/spi_ws_halfdiv.sv
module spi_ws_halfdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(HALF_DIV - 1));
    assign tick = run && last;

    always_comb begin
        if (!run || last)
            cnt_d = '0;
        else
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_ws_txfmt.sv
module spi_ws_txfmt
    import spi_ws_pkg::*;
(
    input  logic [WORD_W-1:0] entry,
    input  logic [LEN_W-1:0]  len_m1,
    output logic [WORD_W-1:0] value
);
    // the word field sits in the upper bytes; move it down to bit 0
    always_comb begin
        unique case (byte_class(len_m1))
            3'd1:    value = {24'd0, entry[31:24]};
            3'd2:    value = {16'd0, entry[31:16]};
            default: value = entry;
        endcase
    end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
    import spi_ws_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [4:0]        cfg_len_m1,
    input  logic              cfg_idle_high,
    input  logic              cfg_input_first,
    input  logic              cfg_loopback,
    input  logic [CNT_W-1:0]  cfg_word_count,
    input  logic [31:0]       tx_data,
    input  logic              tx_valid,
    output logic              tx_pop,
    output logic [31:0]       rx_data,
    output logic              rx_push,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    typedef struct packed {
        ws_state_e         st;
        ws_cfg_t           cfg;
        logic [CNT_W-1:0]  left;
        logic [WORD_W-1:0] txsr;
        logic [WORD_W-1:0] rxsr;
        logic [WORD_W-1:0] rx_out;
        logic [LEN_W-1:0]  idx;
        logic              half;
        logic              push;
    } eng_t;

    eng_t d, q;

    logic              tick;
    logic              div_run;
    logic [WORD_W-1:0] tx_word;
    logic              mosi_int;
    logic              rx_bit;

    assign div_run = (q.st == ST_SHIFT) || (q.st == ST_TAIL);

    spi_ws_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .tick  (tick)
    );

    spi_ws_txfmt u_txfmt (
        .entry  (tx_data),
        .len_m1 (q.cfg.len_m1),
        .value  (tx_word)
    );

    assign mosi_int = (q.st == ST_SHIFT) ? q.txsr[q.idx] : 1'b0;
    assign rx_bit   = q.cfg.loopback ? mosi_int : miso;

    always_comb begin
        d      = q;
        d.push = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.cfg.idle_high = cfg_idle_high;
                if (start && (cfg_word_count != '0)) begin
                    d.cfg.len_m1      = clamp_len(cfg_len_m1);
                    d.cfg.input_first = cfg_input_first;
                    d.cfg.loopback    = cfg_loopback;
                    d.left            = cfg_word_count;
                    d.st              = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (tx_valid) begin
                    d.txsr = tx_word;
                    d.rxsr = '0;
                    d.idx  = q.cfg.len_m1;
                    d.half = 1'b0;
                    d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.half) begin
                        d.rxsr = {q.rxsr[WORD_W-2:0], rx_bit};
                        d.half = 1'b1;
                    end else begin
                        d.half = 1'b0;
                        if (q.idx == '0) begin
                            d.push   = 1'b1;
                            d.rx_out = q.rxsr;
                            d.left   = q.left - CNT_W'(1);
                            d.st     = (q.left == CNT_W'(1)) ? ST_TAIL : ST_LOAD;
                        end else begin
                            d.idx = q.idx - LEN_W'(1);
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (!q.half) begin
                        d.half = 1'b1;
                    end else begin
                        d.half = 1'b0;
                        d.st   = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign tx_pop  = (q.st == ST_LOAD) && tx_valid;
    assign rx_push = q.push;
    assign rx_data = q.rx_out;
    assign mosi    = mosi_int;
    assign cs_n    = (q.st == ST_IDLE);
    assign sclk    = (q.st == ST_SHIFT)
                   ? (q.cfg.idle_high ^ (q.half ^ ~q.cfg.input_first))
                   : q.cfg.idle_high;

endmodule

// File: rtl/spi_ws_checker.sv
module spi_ws_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] cfg_word_count,
    input logic             cs_n,
    input logic             sclk,
    input logic             mosi,
    input logic             tx_valid,
    input logic             tx_pop,
    input logic             rx_push,
    input logic [1:0]       st
);
    logic [CNT_W-1:0] lim_q, seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q  <= '0;
            seen_q <= '0;
        end else if (cs_n && start && (cfg_word_count != '0)) begin
            lim_q  <= cfg_word_count;
            seen_q <= '0;
        end else if (rx_push) begin
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    assert_pop_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_valid && !cs_n));

    assert_push_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ((seen_q < lim_q) && !cs_n));

    assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == 2'd1) && ($past(st) == 2'd1)) |-> ($stable(sclk) && !mosi));

    assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ($past(st) == 2'd3));
endmodule

bind spi_word_shifter spi_ws_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .cfg_word_count (cfg_word_count),
    .cs_n           (cs_n),
    .sclk           (sclk),
    .mosi           (mosi),
    .tx_valid       (tx_valid),
    .tx_pop         (tx_pop),
    .rx_push        (rx_push),
    .st             (q.st)
);

// File: tb/spi_word_shifter_test.sv
module spi_word_shifter_test;
    localparam int HALF  = 2;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4:0] cfg_len_m1 = '0;
    logic cfg_idle_high = 1'b0, cfg_input_first = 1'b0, cfg_loopback = 1'b0;
    logic [CNT_W-1:0] cfg_word_count = '0;
    logic [31:0] tx_data;
    logic tx_valid, tx_pop, rx_push, sclk, mosi, cs_n;
    logic [31:0] rx_data;
    logic miso;

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    int rd = 0, rd0 = 0, avail = 0;
    logic [31:0] fifo [0:7];
    logic [31:0] tx_vals [0:7];
    logic [31:0] mi_vals [0:7];
    logic stream [0:255];
    logic cap [0:255];
    int ptr = 0, ncap = 0, rxk = 0;
    int cur_n = 4, cur_k = 1;
    bit cur_idle = 0, cur_inf = 0, cur_lb = 0, mon_on = 0;
    logic prev_sclk = 1'b0;
    bit tail_on = 0;
    int tail_cnt = 0;
    logic [31:0] seed = 32'h1234_5678;

    assign tx_valid = ((rd - rd0) < avail);
    assign tx_data  = fifo[(rd - rd0) & 7];
    assign miso     = stream[ptr & 255];

    spi_word_shifter #(.HALF_DIV(HALF), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len_m1(cfg_len_m1),
        .cfg_idle_high(cfg_idle_high), .cfg_input_first(cfg_input_first),
        .cfg_loopback(cfg_loopback), .cfg_word_count(cfg_word_count),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_push(rx_push), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [31:0] mkentry(input logic [31:0] v, input int n,
                                            input logic [31:0] j1, input logic [31:0] j2);
        int b;
        longint fmask, nmask, field, e;
        b = (n <= 8) ? 1 : (n <= 16) ? 2 : 4;
        fmask = (64'd1 << (8 * b)) - 1;
        nmask = (64'd1 << n) - 1;
        field = (longint'(v) & nmask) | (longint'(j2) & fmask & ~nmask);
        e = (field << (32 - 8 * b)) | (longint'(j1) & ((64'd1 << (32 - 8 * b)) - 1));
        return e[31:0];
    endfunction

    always @(posedge clk) if (tx_pop) rd <= rd + 1;

    // slave model and receive checker
    always @(negedge clk) begin
        if (mon_on && !cs_n && (sclk != prev_sclk)) begin
            if ((sclk != cur_idle) == cur_inf) begin
                cap[ncap & 255] = mosi;
                ncap++;
            end else begin
                ptr++;
            end
        end
        prev_sclk = sclk;
        if (rx_push) begin
            longint expv;
            expv = cur_lb ? longint'(tx_vals[rxk & 7]) : longint'(mi_vals[rxk & 7]);
            // R3 right-justified, R7 loopback source
            chk(rx_data == expv[31:0], cur_lb ? "R7 loopback rx word" : "R3 rx word",
                longint'(rx_data), expv);
            rxk++;
            if (rxk == cur_k) begin
                tail_on = 1;
                tail_cnt = 0;
            end
        end else if (tail_on) begin
            tail_cnt++;
            if (cs_n) begin
                chk(tail_cnt == 2 * HALF, "R9 cs release delay", tail_cnt, 2 * HALF);
                tail_on = 0;
            end
        end
    end

    task automatic run_xfer(input int field, input bit idl, input bit inf, input bit lb,
                            input int k, input bit stall);
        int n, off, bad_at;
        longint nmask;
        bit ok;
        n = (field < 3) ? 4 : field + 1;
        nmask = (64'd1 << n) - 1;
        cur_n = n; cur_idle = idl; cur_inf = inf; cur_k = k; cur_lb = lb;
        for (int w = 0; w < k; w++) begin
            tx_vals[w] = rnd() & nmask[31:0];
            mi_vals[w] = rnd() & nmask[31:0];
            fifo[w]    = mkentry(tx_vals[w], n, rnd(), rnd());
        end
        for (int i = 0; i < 256; i++) stream[i] = 1'b0;
        off = inf ? 0 : 1;
        for (int w = 0; w < k; w++)
            for (int j = 0; j < n; j++)
                stream[off + w * n + j] = lb ? ~mi_vals[w][n-1-j] : mi_vals[w][n-1-j];
        @(negedge clk);
        cfg_len_m1 = field[4:0]; cfg_idle_high = idl; cfg_input_first = inf;
        cfg_loopback = lb; cfg_word_count = CNT_W'(k);
        rd0 = rd; avail = stall ? 1 : k;
        repeat (2) @(negedge clk);
        chk(sclk == idl, "R5 idle level", sclk, idl);
        ptr = 0; ncap = 0; rxk = 0; prev_sclk = sclk; mon_on = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == 1'b0, "R9 cs asserted after start", cs_n, 0);
        if (stall) begin
            while (rxk < 1) @(negedge clk);
            ok = 1;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                ok &= (sclk == idl) && !cs_n && ((rd - rd0) == 1);
            end
            chk(ok, "R10 stall holds sclk and cs", sclk, idl);
            avail = k;
        end
        while (!cs_n) @(negedge clk);
        @(negedge clk);
        mon_on = 0;
        chk(rxk == k, "R8 push count", rxk, k);
        chk((rd - rd0) == k, "R8 pop count", rd - rd0, k);
        chk(ncap == k * n, "R4 R6 sample edge count", ncap, k * n);
        bad_at = -1;
        for (int j = 0; j < k * n; j++)
            if (bad_at < 0 && cap[j & 255] !== tx_vals[j / n][n - 1 - (j % n)]) bad_at = j;
        // R2 field extraction, R4 MSB first, R1 length
        chk(bad_at < 0, "R2 R4 mosi bit stream", bad_at, -1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lens [0:11];
        bit ok;
        lens = '{4, 5, 7, 8, 9, 12, 15, 16, 17, 24, 31, 32};
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R11 reset pins",
            {cs_n, sclk, mosi}, 3'b100);
        chk(!tx_pop && !rx_push, "R11 reset handshakes", {tx_pop, rx_push}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (lens[i])
            for (int m = 0; m < 4; m++)
                run_xfer(lens[i] - 1, m[1], m[0], lens[i][0], 3, 1'b0);

        // R1 short length codes clamp to four bits
        run_xfer(1, 1'b0, 1'b1, 1'b0, 2, 1'b0);
        run_xfer(0, 1'b1, 1'b0, 1'b0, 2, 1'b0);
        // R10 stalls on an empty FIFO, several modes
        run_xfer(7, 1'b0, 1'b1, 1'b0, 3, 1'b1);
        run_xfer(12, 1'b1, 1'b0, 1'b0, 2, 1'b1);
        run_xfer(31, 1'b1, 1'b1, 1'b1, 2, 1'b1);
        // R8 longer transfer
        run_xfer(9, 1'b0, 1'b0, 1'b0, 8, 1'b0);

        // R8 zero word count is ignored
        @(negedge clk);
        cfg_word_count = '0; rd0 = rd; avail = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ok = 1;
        for (int c = 0; c < 20; c++) begin
            ok &= cs_n && (rd == rd0);
            @(negedge clk);
        end
        chk(ok, "R8 zero count ignored", cs_n, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule